// File: doc/BRIEF.md
# Single-Precision Compare Condition-Code Unit

This unit takes two IEEE-754 single-precision operands and reports their relation as a 2-bit condition code. A mode input chooses a quiet compare, a signaling compare, or a total-order style compare. The total-order compare places -0 below +0. It reports "greater" with the same code as "equal". When the pair is unordered, its code depends on which operand is the NaN.

In the quiet and signaling modes the unit also drives two flags for a status register that lives elsewhere. One flag reports an invalid-operation exception. The other accrues the invalid bit whenever the result is unordered. The total-order mode never raises either flag.

The decision is combinational. Its result is registered, so it appears one cycle after a qualified request: `inValid` high in cycle N gives `outValid` high in cycle N+1, together with the result.

Top module: `fcmpCcUnit`

## Requirements
- R1: After reset, `outValid`, `ccOut`, `invalidFlag` and `unorderedFlag` are all 0.
- R2: When `inValid` is high in cycle N, `outValid` is high in cycle N+1 and the result belongs to the cycle-N operands. When `inValid` is low, `outValid` is low in the following cycle.
- R3: In mode quiet (`mode`=2'b00) and mode signaling (`mode`=2'b01), the code is 0 for equal, 1 for opA<opB, 2 for opA>opB and 3 for unordered. +0 and -0 compare equal.
- R4: A NaN has exponent bits [30:23] all ones and a nonzero fraction [22:0]. A NaN is signaling when bit 22 is 0. Any NaN operand makes the result unordered.
- R5: In quiet mode, `invalidFlag` is 1 only when at least one operand is a signaling NaN.
- R6: In signaling mode, `invalidFlag` is 1 when at least one operand is any NaN.
- R7: In quiet and signaling modes, `unorderedFlag` is 1 exactly when the code is 3.
- R8: In total-order mode (`mode`=2'b10 or 2'b11), `invalidFlag` and `unorderedFlag` are always 0.
- R9: In total-order mode, less gives code 1, and both equal and greater give code 0.
- R10: In total-order mode, if the operands compare equal, opB is exactly +0 (32'h0) and opA is not +0, the code is 1.
- R11: In total-order mode, an unordered pair gives code 3 when opB is a NaN and code 2 otherwise.
- R12: Infinities order by sign: -inf is below all finite values and +inf is above them. Negative finite values order in reverse of their magnitude.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request qualifier |
| mode | input | 2 | 00 quiet, 01 signaling, 1x total-order |
| opA | input | 32 | Operand 1 (single precision) |
| opB | input | 32 | Operand 2 (single precision) |
| outValid | output | 1 | Result valid, one cycle after request |
| ccOut | output | 2 | Condition code |
| invalidFlag | output | 1 | Invalid-operation exception |
| unorderedFlag | output | 1 | Accrue-invalid request on unordered |

## Verification
The hardest case to reach is the total-order -0/+0 rule. It fires only when opB is exactly +0 and opA is -0, and the mirrored pair must still give code 0. The stimulus table places -0 vs +0, +0 vs -0 and -0 vs -0 side by side in total-order mode. It also runs the same pairs in quiet mode, where the code must be 0. The NaN cases are also hard to reach. Quiet and signaling NaNs go into each operand slot separately, so that the unordered code split and each invalid rule are exercised independently.

// File: rtl/fcmpPkg.sv
package fcmpPkg;
  localparam int EXP_W = 8;
  localparam int FRAC_W = 23;
  localparam int WORD_W = 1 + EXP_W + FRAC_W;

  typedef enum logic [1:0] {
    MODE_QUIET  = 2'b00,
    MODE_SIGNAL = 2'b01,
    MODE_TOTAL  = 2'b10,
    MODE_TOTAL2 = 2'b11
  } cmpMode_t;

  typedef enum logic [1:0] {
    REL_EQ = 2'd0,
    REL_LT = 2'd1,
    REL_GT = 2'd2,
    REL_UN = 2'd3
  } relation_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic totalMode;
    logic signalMode;
  } ctrlStrobe_t;
endpackage

// File: rtl/fcmpClassify.sv
module fcmpClassify
  import fcmpPkg::*;
#(
  parameter int EW = EXP_W,
  parameter int FW = FRAC_W
) (
  input  logic [EW+FW:0] word,
  output logic           isNan,
  output logic           isSnan,
  output logic           isZero
);
  localparam int QBIT = FW - 1;
  logic expOnes;
  logic fracNz;
  always_comb begin
    expOnes = &word[EW+FW-1:FW];
    fracNz  = |word[FW-1:0];
    isNan   = expOnes && fracNz;
    isSnan  = isNan && !word[QBIT];
    isZero  = ~|word[EW+FW-1:0];
  end
endmodule

// File: rtl/fcmpDatapath.sv
module fcmpDatapath
  import fcmpPkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strobe,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic [1:0]  ccOut,
  output logic        invalidFlag,
  output logic        unorderedFlag
);
  localparam int MAG_W = W - 1;

  logic nanA, nanB, snanA, snanB, zeroA, zeroB;
  relation_t rel;
  logic [1:0] ccNext;
  logic invNext, unNext;

  fcmpClassify #(.EW(EXP_W), .FW(FRAC_W)) i_clsA (
    .word(opA), .isNan(nanA), .isSnan(snanA), .isZero(zeroA));
  fcmpClassify #(.EW(EXP_W), .FW(FRAC_W)) i_clsB (
    .word(opB), .isNan(nanB), .isSnan(snanB), .isZero(zeroB));

  // IEEE relation of opA against opB
  always_comb begin
    logic [MAG_W-1:0] magA, magB;
    logic signA, signB;
    magA = opA[MAG_W-1:0];
    magB = opB[MAG_W-1:0];
    signA = opA[W-1];
    signB = opB[W-1];
    if (nanA || nanB) rel = REL_UN;
    else if ((zeroA && zeroB) || (opA == opB)) rel = REL_EQ;
    else if (signA != signB) rel = signA ? REL_LT : REL_GT;
    else if (!signA) rel = (magA < magB) ? REL_LT : REL_GT;
    else rel = (magA > magB) ? REL_LT : REL_GT;
  end

  always_comb begin
    ccNext = 2'd0;
    invNext = 1'b0;
    unNext = 1'b0;
    if (strobe.totalMode) begin
      unique case (rel)
        REL_EQ: ccNext = (opB == '0 && opA != '0) ? 2'd1 : 2'd0;
        REL_LT: ccNext = 2'd1;
        REL_GT: ccNext = 2'd0;
        default: ccNext = nanB ? 2'd3 : 2'd2;
      endcase
    end else begin
      ccNext = rel;
      unNext = (rel == REL_UN);
      invNext = strobe.signalMode ? (nanA || nanB) : (snanA || snanB);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ccOut <= 2'd0;
      invalidFlag <= 1'b0;
      unorderedFlag <= 1'b0;
    end else if (strobe.load) begin
      ccOut <= ccNext;
      invalidFlag <= invNext;
      unorderedFlag <= unNext;
    end
  end
endmodule

// File: rtl/fcmpControl.sv
module fcmpControl
  import fcmpPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [1:0]  mode,
  output ctrlStrobe_t strobe,
  output logic        outValid
);
  always_comb begin
    strobe.load = inValid;
    strobe.totalMode = mode[1];
    strobe.signalMode = (mode == MODE_SIGNAL);
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else outValid <= inValid;
  end
endmodule

// File: rtl/fcmpCcUnit.sv
module fcmpCcUnit
  import fcmpPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [1:0]  mode,
  input  logic [31:0] opA,
  input  logic [31:0] opB,
  output logic        outValid,
  output logic [1:0]  ccOut,
  output logic        invalidFlag,
  output logic        unorderedFlag
);
  ctrlStrobe_t strobe;

  fcmpControl i_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .mode(mode),
    .strobe(strobe), .outValid(outValid));

  fcmpDatapath #(.W(WORD_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .opA(opA), .opB(opB),
    .ccOut(ccOut), .invalidFlag(invalidFlag), .unorderedFlag(unorderedFlag));
endmodule

// File: rtl/fcmpCcChecker.sv
module fcmpCcChecker (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic [1:0]  mode,
  input logic [31:0] opA,
  input logic [31:0] opB,
  input logic        outValid,
  input logic [1:0]  ccOut,
  input logic        invalidFlag,
  input logic        unorderedFlag
);
  logic nanA, nanB;
  assign nanA = (&opA[30:23]) && (|opA[22:0]);
  assign nanB = (&opB[30:23]) && (|opB[22:0]);

  assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  assert_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  assert_total_silent_R8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && mode[1]) |=> (!invalidFlag && !unorderedFlag));
  assert_unordered_flag_R7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !mode[1]) |=> (unorderedFlag == (ccOut == 2'd3)));
  assert_nan_unordered_R4: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !mode[1] && (nanA || nanB)) |=> (ccOut == 2'd3));
  assert_signal_invalid_R6: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && mode == 2'b01 && (nanA || nanB)) |=> invalidFlag);
  assert_total_nanb_R11: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && mode[1] && nanB) |=> (ccOut == 2'd3));
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(ccOut));
endmodule

bind fcmpCcUnit fcmpCcChecker i_fcmpCcChecker (
  .clk(clk), .rstN(rstN), .inValid(inValid), .mode(mode), .opA(opA),
  .opB(opB), .outValid(outValid), .ccOut(ccOut), .invalidFlag(invalidFlag),
  .unorderedFlag(unorderedFlag));

// File: tb/test_fcmpCcUnit.sv
module test_fcmpCcUnit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic outValid;
  logic [1:0] ccOut;
  logic invalidFlag;
  logic unorderedFlag;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fcmpCcUnit i_fcmpCcUnit (
    .clk(clk), .rstN(rstN), .inValid(inValid), .mode(mode), .opA(opA),
    .opB(opB), .outValid(outValid), .ccOut(ccOut), .invalidFlag(invalidFlag),
    .unorderedFlag(unorderedFlag));

  localparam logic [31:0] PZ = 32'h0000_0000, NZ = 32'h8000_0000;
  localparam logic [31:0] ONE = 32'h3F80_0000, TWO = 32'h4000_0000;
  localparam logic [31:0] M1 = 32'hBF80_0000, M2 = 32'hC000_0000;
  localparam logic [31:0] PINF = 32'h7F80_0000, NINF = 32'hFF80_0000;
  localparam logic [31:0] QN = 32'h7FC0_0000, SN = 32'h7F80_0001;

  // mode, opA, opB, cc, inv, unord, requirement tag
  typedef struct packed {
    logic [1:0] m;
    logic [31:0] a;
    logic [31:0] b;
    logic [1:0] cc;
    logic inv;
    logic un;
    logic [31:0] tag;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VEC [NV] = '{
    '{2'b00, ONE, ONE, 2'd0, 1'b0, 1'b0, "R3"},
    '{2'b00, ONE, TWO, 2'd1, 1'b0, 1'b0, "R3"},
    '{2'b00, TWO, ONE, 2'd2, 1'b0, 1'b0, "R3"},
    '{2'b00, PZ, NZ, 2'd0, 1'b0, 1'b0, "R3"},
    '{2'b00, NZ, PZ, 2'd0, 1'b0, 1'b0, "R3"},
    '{2'b00, M2, M1, 2'd1, 1'b0, 1'b0, "R12"},
    '{2'b00, M1, ONE, 2'd1, 1'b0, 1'b0, "R12"},
    '{2'b00, NINF, M2, 2'd1, 1'b0, 1'b0, "R12"},
    '{2'b00, PINF, TWO, 2'd2, 1'b0, 1'b0, "R12"},
    '{2'b00, QN, ONE, 2'd3, 1'b0, 1'b1, "R5"},
    '{2'b00, ONE, SN, 2'd3, 1'b1, 1'b1, "R5"},
    '{2'b00, SN, QN, 2'd3, 1'b1, 1'b1, "R4"},
    '{2'b00, PINF, PINF, 2'd0, 1'b0, 1'b0, "R4"},
    '{2'b01, ONE, QN, 2'd3, 1'b1, 1'b1, "R6"},
    '{2'b01, SN, ONE, 2'd3, 1'b1, 1'b1, "R6"},
    '{2'b01, M1, TWO, 2'd1, 1'b0, 1'b0, "R6"},
    '{2'b01, TWO, TWO, 2'd0, 1'b0, 1'b0, "R7"},
    '{2'b10, ONE, ONE, 2'd0, 1'b0, 1'b0, "R9"},
    '{2'b10, ONE, TWO, 2'd1, 1'b0, 1'b0, "R9"},
    '{2'b10, TWO, ONE, 2'd0, 1'b0, 1'b0, "R9"},
    '{2'b11, M1, ONE, 2'd1, 1'b0, 1'b0, "R9"},
    '{2'b10, NZ, PZ, 2'd1, 1'b0, 1'b0, "R10"},
    '{2'b10, PZ, NZ, 2'd0, 1'b0, 1'b0, "R10"},
    '{2'b10, NZ, NZ, 2'd0, 1'b0, 1'b0, "R10"},
    '{2'b10, PZ, PZ, 2'd0, 1'b0, 1'b0, "R10"},
    '{2'b10, ONE, QN, 2'd3, 1'b0, 1'b0, "R11"},
    '{2'b10, QN, ONE, 2'd2, 1'b0, 1'b0, "R11"},
    '{2'b11, SN, SN, 2'd3, 1'b0, 1'b0, "R8"},
    '{2'b10, SN, TWO, 2'd2, 1'b0, 1'b0, "R8"},
    '{2'b11, NINF, M2, 2'd1, 1'b0, 1'b0, "R12"}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] m, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    inValid = 1'b1; mode = m; opA = a; opB = b;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hang expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", {28'd0, outValid, ccOut, invalidFlag, unorderedFlag}, 32'd0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i].m, VEC[i].a, VEC[i].b);
      check("R2", {31'd0, outValid}, 32'd1);
      check(string'(VEC[i].tag), {30'd0, ccOut}, {30'd0, VEC[i].cc});
      check("R5/R6/R8 inv", {31'd0, invalidFlag}, {31'd0, VEC[i].inv});
      check("R7/R8 unord", {31'd0, unorderedFlag}, {31'd0, VEC[i].un});
    end

    // R2: idle cycle drops outValid and holds result
    issue(2'b00, TWO, ONE);
    @(negedge clk);
    check("R2 idle", {31'd0, outValid}, 32'd0);
    check("R2 hold", {30'd0, ccOut}, 32'd2);

    // R1: reset in mid-stream clears outputs
    issue(2'b01, QN, QN);
    rstN = 1'b0;
    @(negedge clk);
    check("R1 rereset", {28'd0, outValid, ccOut, invalidFlag, unorderedFlag}, 32'd0);
    rstN = 1'b1;

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule